// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetcher

This block moves frame data and palette data out of memory and into a display output FIFO. It does not use a fixed transfer list. It walks a chain of descriptors. Each descriptor is four consecutive 32-bit words. It names where the data lives, a frame tag, a length and a kind (pixels or palette), and it points at the descriptor that comes after it.

A descriptor that points at itself makes the block send the same frame forever. This is the usual setup for true-colour output. Two descriptors that point at each other make the block send a palette load and then a frame, over and over, for palette-indexed output.

Software writes the first descriptor's word address and then raises the enable. The block issues word-addressed burst reads of 4, 8 or 16 words. The last burst of a transfer may be shorter. A data burst is issued only when the downstream FIFO reports enough free entries for the whole burst.

Read data passes straight to the output stream, with a flag that marks palette words. Three stream rules apply:
- The memory request channel holds `mem_req_valid`, the address and the length steady until `mem_req_ready` is high.
- The read-data channel is paced by `mem_rready`. During data bursts this follows `out_ready`, so a stalled sink stalls memory.
- The output holds its word and flag while `out_ready` is low.

Top module: `frame_desc_dma`

## Requirements
- R1: After reset the block is idle. `stat_busy`, `mem_req_valid`, `out_valid` and `mem_rready` are all 0.
- R2: When `en` is high in idle, the block issues a 4-word read at `start_addr`. `start_addr` is sampled on the cycle that enable is seen.
- R3: Descriptor words are read in this order: word 0 is the next-descriptor address, word 1 is the source address, word 2 is the frame ID, word 3 is the command. `stat_frame_id` and `stat_cmd` show words 2 and 3, and data reads start at word 1.
- R4: Command bits 23:0 give the transfer length in 32-bit words. Exactly that many words are delivered, in address order. A length of 0 delivers nothing and goes straight to the next descriptor.
- R5: Command bit 28 set marks a palette transfer. `out_palette` and `stat_palette` are 1 for its words and 0 for pixel transfers.
- R6: After the last word of a transfer, the descriptor at the next-address pointer is fetched. A self-pointing descriptor repeats its frame. Two descriptors that point at each other alternate.
- R7: `burst_sel` picks the burst size: 0 gives 4 words, 1 gives 8 words, 2 and 3 give 16 words. Each data burst is the smaller of the burst size and the words remaining, so the final burst may be shorter.
- R8: A data burst of N words is requested only while `fifo_space` is at least N. Descriptor reads are not gated.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the valid, address and length stay unchanged.
- R10: While `out_ready` is low, `out_valid`, `out_data` and `out_palette` hold, and `mem_rready` is 0 during a data burst.
- R11: Dropping `en` lets the current burst (data or descriptor) finish. After that the block issues no request and returns to idle. A later enable restarts from `start_addr`.
- R12: `stat_src` is loaded with the source address when a transfer begins. It advances by one for each word delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable |
| start_addr | input | AW | Word address of first descriptor |
| burst_sel | input | 2 | Burst size code |
| fifo_space | input | SPACE_W | Free entries in downstream FIFO |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | AW | Request start word address |
| mem_req_len | output | 5 | Request length in words (1..16) |
| mem_rvalid | input | 1 | Read data valid |
| mem_rready | output | 1 | Read data accepted |
| mem_rdata | input | 32 | Read data word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | FIFO accepts word |
| out_data | output | 32 | Output word |
| out_palette | output | 1 | Output word belongs to a palette transfer |
| stat_busy | output | 1 | Block is not idle |
| stat_src | output | AW | Current source word address |
| stat_frame_id | output | 32 | Frame ID of current descriptor |
| stat_cmd | output | 32 | Command of current descriptor |
| stat_palette | output | 1 | Current descriptor is a palette load |

## Verification
The bench targets these corner cases, with the fault each one exposes:
- **Short final burst.** A 10-word frame with 4-word bursts, and a 3-word palette with 8-word bursts, must end in a short burst. A design that always requested full bursts would read past the frame.
- **Zero-length descriptor.** The block must skip it without touching its source. A wrong design would read a stray word or hang.
- **FIFO space one short.** `fifo_space` is held exactly one entry below the pending burst. A design with an off-by-one in the gate would issue early.
- **Stalls mid-burst.** The request channel and the sink are both stalled. A design that let go of its request or data would show changed values while stalled.
- **Enable dropped mid-run.** The word count must equal the sum of issued data bursts. A design that stopped mid-burst would leave memory data undrained. A re-enable at a new start address checks that the walk restarts there.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 4;
  localparam int PAL_BIT    = 28;
  localparam int MAX_BURST  = 16;
  localparam int BLEN_W     = $clog2(MAX_BURST + 1);

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for enable
    ST_DREQ,   // requesting a descriptor
    ST_DRD,    // receiving descriptor words
    ST_DCHK,   // deciding what the descriptor asks for
    ST_XWAIT,  // waiting for FIFO room
    ST_XREQ,   // requesting a data burst
    ST_XRD     // streaming data words out
  } fetch_state_t;

  function automatic logic [BLEN_W-1:0] burst_words(input logic [1:0] code);
    case (code)
      2'd0:    return BLEN_W'(4);
      2'd1:    return BLEN_W'(8);
      default: return BLEN_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/fdma_desc_regs.sv
module fdma_desc_regs
  import fdma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        idx,
  input  logic [WORD_W-1:0] word,
  output logic [AW-1:0]     next_addr,
  output logic [AW-1:0]     src_addr,
  output logic [WORD_W-1:0] frame_id,
  output logic [WORD_W-1:0] cmd,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              is_palette
);
  logic [WORD_W-1:0] slot [DESC_WORDS];

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot[g] <= '0;
      else if (load && idx == 2'(g))
        slot[g] <= word;
    end
  end

  assign next_addr  = slot[0][AW-1:0];
  assign src_addr   = slot[1][AW-1:0];
  assign frame_id   = slot[2];
  assign cmd        = slot[3];
  assign xfer_len   = slot[3][LEN_W-1:0];
  assign is_palette = slot[3][PAL_BIT];
endmodule

// File: rtl/fdma_burst_calc.sv
module fdma_burst_calc
  import fdma_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int SPACE_W = 7
) (
  input  logic [1:0]         burst_sel,
  input  logic [LEN_W-1:0]   remain,
  input  logic [SPACE_W-1:0] space,
  output logic [BLEN_W-1:0]  blen,
  output logic               room_ok
);
  logic [BLEN_W-1:0] bsize;

  always_comb begin
    bsize   = burst_words(burst_sel);
    blen    = (remain < LEN_W'(bsize)) ? remain[BLEN_W-1:0] : bsize;
    room_ok = (32'(space) >= 32'(blen));
  end
endmodule

// File: rtl/frame_desc_dma.sv
module frame_desc_dma
  import fdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LEN_W      = 24,
  parameter int FIFO_DEPTH = 64,
  localparam int SPACE_W   = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [AW-1:0]      start_addr,
  input  logic [1:0]         burst_sel,
  input  logic [SPACE_W-1:0] fifo_space,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [AW-1:0]      mem_req_addr,
  output logic [BLEN_W-1:0]  mem_req_len,
  input  logic               mem_rvalid,
  output logic               mem_rready,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_data,
  output logic               out_palette,
  output logic               stat_busy,
  output logic [AW-1:0]      stat_src,
  output logic [WORD_W-1:0]  stat_frame_id,
  output logic [WORD_W-1:0]  stat_cmd,
  output logic               stat_palette
);
  fetch_state_t      state;
  logic [AW-1:0]     desc_addr, cur_src, d_next, d_src;
  logic [LEN_W-1:0]  remain, d_len;
  logic [BLEN_W-1:0] beats, req_len, blen;
  logic [1:0]        didx;
  logic              room_ok, d_pal, desc_load, word_xfer;

  fdma_desc_regs #(.AW(AW), .LEN_W(LEN_W)) u_desc (
    .clk(clk), .rst_n(rst_n), .load(desc_load), .idx(didx), .word(mem_rdata),
    .next_addr(d_next), .src_addr(d_src), .frame_id(stat_frame_id),
    .cmd(stat_cmd), .xfer_len(d_len), .is_palette(d_pal)
  );

  fdma_burst_calc #(.LEN_W(LEN_W), .SPACE_W(SPACE_W)) u_burst (
    .burst_sel(burst_sel), .remain(remain), .space(fifo_space),
    .blen(blen), .room_ok(room_ok)
  );

  assign desc_load = (state == ST_DRD) && mem_rvalid;
  assign word_xfer = (state == ST_XRD) && mem_rvalid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      desc_addr <= '0;
      cur_src   <= '0;
      remain    <= '0;
      beats     <= '0;
      req_len   <= '0;
      didx      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (en) begin
          desc_addr <= start_addr;
          state     <= ST_DREQ;
        end
        ST_DREQ: if (mem_req_ready) begin
          didx  <= '0;
          state <= ST_DRD;
        end
        ST_DRD: if (mem_rvalid) begin
          didx <= didx + 2'd1;
          if (didx == 2'(DESC_WORDS - 1)) state <= ST_DCHK;
        end
        ST_DCHK: begin
          if (!en) begin
            state <= ST_IDLE;
          end else if (d_len == '0) begin
            desc_addr <= d_next;
            state     <= ST_DREQ;
          end else begin
            cur_src <= d_src;
            remain  <= d_len;
            state   <= ST_XWAIT;
          end
        end
        ST_XWAIT: begin
          if (!en) begin
            state <= ST_IDLE;
          end else if (room_ok) begin
            req_len <= blen;
            state   <= ST_XREQ;
          end
        end
        ST_XREQ: if (mem_req_ready) begin
          beats <= req_len;
          state <= ST_XRD;
        end
        ST_XRD: if (word_xfer) begin
          cur_src <= cur_src + AW'(1);
          remain  <= remain - LEN_W'(1);
          beats   <= beats - BLEN_W'(1);
          if (beats == BLEN_W'(1)) begin
            if (!en) begin
              state <= ST_IDLE;
            end else if (remain == LEN_W'(1)) begin
              desc_addr <= d_next;
              state     <= ST_DREQ;
            end else begin
              state <= ST_XWAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = (state == ST_DREQ) || (state == ST_XREQ);
    mem_req_addr  = (state == ST_DREQ) ? desc_addr : cur_src;
    mem_req_len   = (state == ST_DREQ) ? BLEN_W'(DESC_WORDS) : req_len;
    mem_rready    = (state == ST_DRD) || ((state == ST_XRD) && out_ready);
    out_valid     = (state == ST_XRD) && mem_rvalid;
    out_data      = mem_rdata;
    out_palette   = d_pal;
  end

  assign stat_busy    = (state != ST_IDLE);
  assign stat_src     = cur_src;
  assign stat_palette = d_pal;
endmodule

// File: rtl/fdma_checks.sv
module fdma_checks
  import fdma_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [AW-1:0]     mem_req_addr,
  input logic [BLEN_W-1:0] mem_req_len,
  input logic              mem_rready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_palette,
  input logic              stat_busy
);
  // R1: an idle block drives no traffic
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_busy |-> (!mem_req_valid && !out_valid && !mem_rready));

  // R7: every request length lies in 1..MAX_BURST
  assert_burst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_len != '0 && 32'(mem_req_len) <= MAX_BURST));

  // R9: a pending request is held steady
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len)));

  // R10: a stalled output word is held
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_palette)));

  // R11: with enable low, an idle block stays idle
  assert_stay_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !stat_busy) |=> !stat_busy);
endmodule

bind frame_desc_dma fdma_checks #(.AW(AW)) u_fdma_checks (
  .clk(clk), .rst_n(rst_n), .en(en),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
  .mem_rready(mem_rready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_palette(out_palette), .stat_busy(stat_busy)
);

// File: tb/frame_desc_dma_tb.sv
module frame_desc_dma_tb;
  localparam int AW = 32;
  localparam int SPACE_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0] burst_sel = 2'd0;
  logic [SPACE_W-1:0] fifo_space = 7'd64;
  logic mem_req_valid, mem_req_ready, mem_rvalid, mem_rready;
  logic [AW-1:0] mem_req_addr;
  logic [4:0] mem_req_len;
  logic [31:0] mem_rdata, out_data, stat_frame_id, stat_cmd;
  logic out_valid, out_palette, stat_busy, stat_palette;
  logic out_ready = 1'b1;
  logic req_gate = 1'b1;
  logic [AW-1:0] stat_src;

  always #4 clk = ~clk;

  frame_desc_dma u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .start_addr(start_addr),
    .burst_sel(burst_sel), .fifo_space(fifo_space),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
    .mem_rvalid(mem_rvalid), .mem_rready(mem_rready), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_palette(out_palette), .stat_busy(stat_busy), .stat_src(stat_src),
    .stat_frame_id(stat_frame_id), .stat_cmd(stat_cmd), .stat_palette(stat_palette)
  );

  // memory model and logs
  logic [31:0] mem [256];
  logic m_busy = 1'b0;
  logic [7:0] m_addr = '0;
  logic [4:0] m_left = '0;
  int req_n = 0, out_n = 0;
  logic [31:0] rq_addr [512];
  logic [4:0]  rq_len  [512];
  logic [31:0] ob_data [512];
  logic        ob_pal  [512];

  assign mem_req_ready = !m_busy && req_gate;
  assign mem_rvalid    = m_busy;
  assign mem_rdata     = mem[m_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready) begin
        m_busy <= 1'b1;
        m_addr <= mem_req_addr[7:0];
        m_left <= mem_req_len;
        rq_addr[req_n] <= mem_req_addr;
        rq_len[req_n]  <= mem_req_len;
        req_n <= req_n + 1;
      end else if (m_busy && mem_rready) begin
        m_addr <= m_addr + 8'd1;
        m_left <= m_left - 5'd1;
        if (m_left == 5'd1) m_busy <= 1'b0;
      end
      if (out_valid && out_ready) begin
        ob_data[out_n] <= out_data;
        ob_pal[out_n]  <= out_palette;
        out_n <= out_n + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic put_desc(input int a, input logic [31:0] nx, input logic [31:0] src,
                          input logic [31:0] fid, input logic [31:0] cmd);
    mem[a] = nx; mem[a+1] = src; mem[a+2] = fid; mem[a+3] = cmd;
  endtask

  task automatic wait_out(input int target);
    for (int i = 0; i < 2000 && out_n < target; i++) @(negedge clk);
  endtask

  task automatic stop_and_idle();
    en = 1'b0;
    for (int i = 0; i < 200 && stat_busy; i++) @(negedge clk);
    chk("R11 idle after enable drop", {31'd0, stat_busy}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'd0, stat_busy}, 32'd0);
    chk("R1 req valid", {31'd0, mem_req_valid}, 32'd0);
    chk("R1 out valid", {31'd0, out_valid}, 32'd0);
    chk("R1 rready", {31'd0, mem_rready}, 32'd0);
  endtask

  // true-colour self-loop, 10 words, 4-word bursts
  task automatic t_selfloop();
    int rb, ob, sum;
    rb = req_n; ob = out_n;
    put_desc(8'h10, 32'h10, 32'h40, 32'h55, 32'd10);
    burst_sel = 2'd0; start_addr = 32'h10; en = 1'b1;
    wait_out(ob + 20);
    stop_and_idle();
    chk("R2 first req addr", rq_addr[rb], 32'h10);
    chk("R2 first req len", {27'd0, rq_len[rb]}, 32'd4);
    chk("R3 data from src", rq_addr[rb+1], 32'h40);
    chk("R7 burst 4", {27'd0, rq_len[rb+2]}, 32'd4);
    chk("R7 short last burst addr", rq_addr[rb+3], 32'h48);
    chk("R7 short last burst len", {27'd0, rq_len[rb+3]}, 32'd2);
    chk("R6 self loop refetch", rq_addr[rb+4], 32'h10);
    for (int i = 0; i < 20; i++) begin
      chk("R4 R6 frame words", ob_data[ob+i], mem[8'h40 + (i % 10)]);
      chk("R5 pixel flag", {31'd0, ob_pal[ob+i]}, 32'd0);
    end
    chk("R3 frame id", stat_frame_id, 32'h55);
    chk("R3 cmd", stat_cmd, 32'd10);
    sum = 0;
    for (int i = rb; i < req_n; i++) if (rq_addr[i] >= 32'h40) sum += int'(rq_len[i]);
    chk("R11 whole bursts only", 32'(out_n - ob), 32'(sum));
    rb = req_n;
    repeat (30) @(negedge clk);
    chk("R11 no request after stop", 32'(req_n), 32'(rb));
  endtask

  // palette / frame alternation, 8-word bursts
  task automatic t_palette();
    int rb, ob;
    rb = req_n; ob = out_n;
    put_desc(8'h20, 32'h24, 32'h80, 32'hA1, (32'd1 << 28) | 32'd3);
    put_desc(8'h24, 32'h20, 32'h90, 32'hB2, 32'd5);
    burst_sel = 2'd1; start_addr = 32'h20; en = 1'b1;
    wait_out(ob + 11);
    stop_and_idle();
    chk("R7 palette short burst", {27'd0, rq_len[rb+1]}, 32'd3);
    chk("R6 alternate to frame", rq_addr[rb+2], 32'h24);
    chk("R7 frame burst len", {27'd0, rq_len[rb+3]}, 32'd5);
    chk("R6 back to palette", rq_addr[rb+4], 32'h20);
    for (int i = 0; i < 11; i++) begin
      if (i < 3 || i >= 8) begin
        chk("R5 palette word", ob_data[ob+i], mem[8'h80 + (i % 8)]);
        chk("R5 palette flag", {31'd0, ob_pal[ob+i]}, 32'd1);
      end else begin
        chk("R5 frame word", ob_data[ob+i], mem[8'h90 + i - 3]);
        chk("R5 frame flag", {31'd0, ob_pal[ob+i]}, 32'd0);
      end
    end
  endtask

  // FIFO space gating, 16-word bursts
  task automatic t_space();
    int rb, ob;
    rb = req_n; ob = out_n;
    put_desc(8'h30, 32'h30, 32'hA0, 32'h77, 32'd20);
    burst_sel = 2'd2; fifo_space = 7'd15; start_addr = 32'h30; en = 1'b1;
    repeat (40) @(negedge clk);
    chk("R8 gated at 15 of 16", 32'(req_n - rb), 32'd1);
    chk("R8 no data out", 32'(out_n - ob), 32'd0);
    chk("R12 src loaded", stat_src, 32'hA0);
    chk("R3 frame id", stat_frame_id, 32'h77);
    chk("R3 palette status", {31'd0, stat_palette}, 32'd0);
    fifo_space = 7'd16;
    wait_out(ob + 16);
    fifo_space = 7'd0;
    chk("R7 burst 16", {27'd0, rq_len[rb+1]}, 32'd16);
    repeat (20) @(negedge clk);
    chk("R12 src advanced", stat_src, 32'hB0);
    fifo_space = 7'd3;
    repeat (20) @(negedge clk);
    chk("R8 gated at 3 of 4", 32'(req_n - rb), 32'd2);
    fifo_space = 7'd4;
    wait_out(ob + 20);
    chk("R8 released tail addr", rq_addr[rb+2], 32'hB0);
    chk("R8 released tail len", {27'd0, rq_len[rb+2]}, 32'd4);
    chk("R4 last word", ob_data[ob+19], mem[8'hB3]);
    stop_and_idle();
    fifo_space = 7'd64;
  endtask

  // zero-length descriptor is skipped
  task automatic t_zero();
    int rb, ob;
    rb = req_n; ob = out_n;
    put_desc(8'h00, 32'h08, 32'hC0, 32'h1, 32'd0);
    put_desc(8'h08, 32'h08, 32'hC8, 32'h2, 32'd2);
    burst_sel = 2'd0; start_addr = 32'h00; en = 1'b1;
    wait_out(ob + 2);
    stop_and_idle();
    chk("R4 zero len goes to next", rq_addr[rb+1], 32'h08);
    chk("R4 zero len data addr", rq_addr[rb+2], 32'hC8);
    chk("R4 zero len data len", {27'd0, rq_len[rb+2]}, 32'd2);
    chk("R4 word 0", ob_data[ob], mem[8'hC8]);
    chk("R4 word 1", ob_data[ob+1], mem[8'hC9]);
  endtask

  // request stall and output back-pressure
  task automatic t_stall();
    int ob;
    logic [31:0] held;
    ob = out_n;
    put_desc(8'h10, 32'h10, 32'h40, 32'h55, 32'd10);
    burst_sel = 2'd0; start_addr = 32'h10;
    req_gate = 1'b0; out_ready = 1'b0; en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9 req held valid", {31'd0, mem_req_valid}, 32'd1);
      chk("R9 req held addr", mem_req_addr, 32'h10);
      chk("R9 req held len", {27'd0, mem_req_len}, 32'd4);
    end
    req_gate = 1'b1;
    for (int i = 0; i < 100 && !out_valid; i++) @(negedge clk);
    held = out_data;
    chk("R10 first stalled word", held, mem[8'h40]);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R10 valid held", {31'd0, out_valid}, 32'd1);
      chk("R10 data held", out_data, held);
      chk("R10 rready low", {31'd0, mem_rready}, 32'd0);
    end
    out_ready = 1'b1;
    wait_out(ob + 10);
    stop_and_idle();
    for (int i = 0; i < 10; i++) chk("R10 order after stall", ob_data[ob+i], mem[8'h40 + i]);
  endtask

  // re-enable restarts at a new start address
  task automatic t_restart();
    int rb, ob;
    rb = req_n; ob = out_n;
    burst_sel = 2'd1; start_addr = 32'h24; en = 1'b1;
    wait_out(ob + 5);
    stop_and_idle();
    chk("R11 restart addr", rq_addr[rb], 32'h24);
    chk("R11 restart data addr", rq_addr[rb+1], 32'h90);
    chk("R11 restart word", ob_data[ob+4], mem[8'h94]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hD000_0000 + 32'(i * 7);
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_selfloop();
    t_palette();
    t_space();
    t_zero();
    t_stall();
    t_restart();
    summary();
    $finish;
  end
endmodule